// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the bit-clock timing for an I2C master. A free-running system clock is first divided by a programmable prescaler. The divided ticks then drive two nested counters, an inner step counter and an outer sample counter. Each SCL half period lasts sample × step divided ticks, so the bus frequency is the system clock divided by (divider × 2 × sample × step). The block does not move SCL or SDA pins itself. It gives a bit-level engine a registered SCL level and four single-cycle quarter strobes: start of the low half, middle of the low half (the point to change SDA), start of the high half, and middle of the high half (the point to sample SDA).

There are two counter sets. The normal set serves standard and fast speeds. A separately packed high-speed set is used only when its enable field holds the enabling code. When high speed is enabled, the engine runs the master-code phase on the normal set. It then pulses a phase-switch input, and the high-speed set takes over at the next SCL period boundary. All configuration inputs are captured while the generator is idle, so a write made mid-transfer waits for the next start.

Top module: `scl_tg_top`

## Requirements
- R1: One SCL period lasts exactly 2 × D × S × T system clock cycles, where D is the divider, S the sample count and T the step count of the active set; each half period holds S × T divided ticks.
- R2: The divider input carries D − 1, so 0 gives one divided tick per clock and 3 gives one tick every four clocks.
- R3: In the normal timing word, bits [5:0] hold T − 1 (T from 1 to 64) and bits [10:8] hold S − 1 (S from 1 to 8); all other bits have no effect.
- R4: In the high-speed word, bits [1:0] equal to 3 enable the high-speed set, bits [10:8] hold its T − 1 (1 to 8) and bits [14:12] hold its S − 1 (1 to 8); any other enable value leaves the normal set in use and makes the phase-switch input have no effect.
- R5: When run is sampled high while idle, busy rises on that edge, and SCL falls together with the first low-start strobe D clock edges later.
- R6: Within a half period of N = S × T divided ticks, numbered from 0, the start strobe fires on tick 0 and the mid strobe on tick floor(N/2); the low and high halves are kept apart; each strobe is one cycle wide; with N = 1 the start and mid strobes of a half coincide.
- R7: SCL is low for the low half, and it is high for the high half and while idle.
- R8: A transfer always starts on the normal set. A phase-switch pulse while busy with high speed enabled makes the high-speed set active, and raises the high-speed flag, from the end of the current high half. A pulse while idle is ignored.
- R9: The divider and both timing words are captured only while idle; changes while busy have no effect until the next start.
- R10: When run is low at the end of a high half, the generator goes idle: busy and the high-speed flag fall and SCL stays high. A drop of run earlier in a period lets that period finish.
- R11: After reset SCL is high and busy, the high-speed flag and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Request SCL periods; sampled at every period end |
| phase_sw_i | input | 1 | Pulse from the engine marking the end of the master-code phase |
| div_cfg_i | input | DIV_W | Prescaler divider minus one |
| tim_cfg_i | input | REG_W | Normal timing word (step and sample fields) |
| hs_cfg_i | input | REG_W | High-speed word (enable, step and sample fields) |
| scl_o | output | 1 | Registered SCL level |
| q_low_start_o | output | 1 | Strobe at the first tick of the low half |
| q_low_mid_o | output | 1 | Strobe at the middle of the low half (SDA change point) |
| q_high_start_o | output | 1 | Strobe at the first tick of the high half |
| q_sample_o | output | 1 | Strobe at the middle of the high half (SDA sample point) |
| busy_o | output | 1 | Generator is running periods |
| hs_active_o | output | 1 | High-speed counter set is in use |

## Verification
The divider and counters are exercised at both ends of their range. A fully degenerate 1×1×1 setting shows whether the coincident start and mid strobes and the two-cycle period are right. A 4×3×5 setting, with junk in the unused bits, separates the divider from the counter product and shows whether the odd-length midpoint rounds down. The largest 8×64 product shows whether the counters overflow. Switch pulses given while idle, mid-transfer and with a wrong enable code show whether the high-speed set is entered only on a legal, busy request, and only at a period boundary. An early drop of run shows whether the final period is completed rather than cut off.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    // counter field widths
    localparam int STEP_W    = 6;
    localparam int SAMP_W    = 3;
    localparam int HS_STEP_W = 3;
    localparam int HS_SAMP_W = 3;

    // field positions inside the two timing words
    localparam int NRM_STEP_LSB = 0;
    localparam int NRM_SAMP_LSB = 8;
    localparam int HS_EN_LSB    = 0;
    localparam int HS_EN_W      = 2;
    localparam int HS_STEP_LSB  = 8;
    localparam int HS_SAMP_LSB  = 12;
    localparam logic [HS_EN_W-1:0] HS_EN_CODE = 2'b11;

    // position inside a half period and half-period length
    localparam int POS_W = STEP_W + SAMP_W;
    localparam int LEN_W = POS_W + 1;

    typedef struct packed {
        logic [STEP_W-1:0] step_m1;
        logic [SAMP_W-1:0] samp_m1;
    } cnt_set_t;

    typedef struct packed {
        cnt_set_t nrm;
        cnt_set_t fast;
        logic     hs_en;
    } tcfg_t;

    typedef enum logic [1:0] {
        Q_LOW_START  = 2'd0,
        Q_LOW_MID    = 2'd1,
        Q_HIGH_START = 2'd2,
        Q_HIGH_MID   = 2'd3
    } quarter_e;

endpackage

// File: rtl/scl_tg_decode.sv
module scl_tg_decode
    import scl_tg_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0] tim_cfg_i,
    input  logic [REG_W-1:0] hs_cfg_i,
    output tcfg_t            cfg_o
);

    // bits outside the fields carry no meaning
    logic cfg_unused;
    assign cfg_unused = ^{tim_cfg_i, hs_cfg_i};

    always_comb begin
        cfg_o.nrm.step_m1  = tim_cfg_i[NRM_STEP_LSB +: STEP_W];
        cfg_o.nrm.samp_m1  = tim_cfg_i[NRM_SAMP_LSB +: SAMP_W];
        cfg_o.fast.step_m1 = STEP_W'(hs_cfg_i[HS_STEP_LSB +: HS_STEP_W]);
        cfg_o.fast.samp_m1 = SAMP_W'(hs_cfg_i[HS_SAMP_LSB +: HS_SAMP_W]);
        cfg_o.hs_en        = (hs_cfg_i[HS_EN_LSB +: HS_EN_W] == HS_EN_CODE);
    end

endmodule

// File: rtl/scl_tg_prediv.sv
module scl_tg_prediv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pd_t;

    pd_t pd_d, pd_q;

    always_comb begin
        tick_o = en_i && (pd_q.cnt == div_m1_i);
        pd_d   = pd_q;
        if (!en_i || tick_o) begin
            pd_d.cnt = '0;
        end else begin
            pd_d.cnt = pd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q <= '0;
        end else begin
            pd_q <= pd_d;
        end
    end

endmodule

// File: rtl/scl_tg_phase.sv
module scl_tg_phase
    import scl_tg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       sw_i,
    input  logic       tick_i,
    input  tcfg_t      cfg_i,
    output logic       scl_o,
    output logic [3:0] qtr_o,
    output logic       busy_o,
    output logic       hs_o
);

    typedef struct packed {
        logic              busy;
        logic              high;
        logic              hs;
        logic              pend;
        logic              scl;
        logic [STEP_W-1:0] step;
        logic [SAMP_W-1:0] samp;
        logic [3:0]        qtr;
    } ph_t;

    localparam ph_t PH_RST = '{busy: 1'b0, high: 1'b0, hs: 1'b0, pend: 1'b0,
                               scl: 1'b1, step: '0, samp: '0, qtr: '0};

    ph_t            ph_d, ph_q;
    cnt_set_t       cur;
    logic [LEN_W-1:0] step_n, samp_n, len, mid, pos;
    logic [3:0]     hit;
    logic           step_end, samp_end, half_end, pend_now;

    // active counter set and position inside the current half
    assign cur    = ph_q.hs ? cfg_i.fast : cfg_i.nrm;
    assign step_n = LEN_W'(cur.step_m1) + LEN_W'(1);
    assign samp_n = LEN_W'(cur.samp_m1) + LEN_W'(1);
    assign len    = samp_n * step_n;
    assign mid    = len >> 1;
    assign pos    = LEN_W'(ph_q.samp) * step_n + LEN_W'(ph_q.step);

    // one comparator per quarter strobe
    for (genvar gq = 0; gq < 4; gq++) begin : g_qtr
        localparam bit IS_HIGH = (gq >= 2);
        localparam bit IS_MID  = ((gq % 2) == 1);
        assign hit[gq] = (ph_q.high == IS_HIGH) &&
                         (pos == (IS_MID ? mid : LEN_W'(0)));
    end

    always_comb begin
        ph_d     = ph_q;
        ph_d.qtr = '0;
        pend_now = ph_q.pend | (sw_i & cfg_i.hs_en & ~ph_q.hs & ph_q.busy);
        step_end = (ph_q.step == cur.step_m1);
        samp_end = (ph_q.samp == cur.samp_m1);
        half_end = step_end && samp_end;

        if (!ph_q.busy) begin
            if (run_i) begin
                ph_d.busy = 1'b1;
            end
        end else begin
            ph_d.pend = pend_now;
            if (tick_i) begin
                ph_d.qtr = hit;
                if (hit[Q_LOW_START]) begin
                    ph_d.scl = 1'b0;
                end
                if (hit[Q_HIGH_START]) begin
                    ph_d.scl = 1'b1;
                end
                if (step_end) begin
                    ph_d.step = '0;
                    ph_d.samp = samp_end ? '0 : ph_q.samp + 1'b1;
                end else begin
                    ph_d.step = ph_q.step + 1'b1;
                end
                if (half_end) begin
                    ph_d.high = ~ph_q.high;
                    if (ph_q.high) begin
                        if (!run_i) begin
                            ph_d.busy = 1'b0;
                            ph_d.hs   = 1'b0;
                            ph_d.pend = 1'b0;
                        end else if (pend_now) begin
                            ph_d.hs   = 1'b1;
                            ph_d.pend = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_RST;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign scl_o  = ph_q.scl;
    assign qtr_o  = ph_q.qtr;
    assign busy_o = ph_q.busy;
    assign hs_o   = ph_q.hs;

endmodule

// File: rtl/scl_tg_top.sv
module scl_tg_top
    import scl_tg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             phase_sw_i,
    input  logic [DIV_W-1:0] div_cfg_i,
    input  logic [REG_W-1:0] tim_cfg_i,
    input  logic [REG_W-1:0] hs_cfg_i,
    output logic             scl_o,
    output logic             q_low_start_o,
    output logic             q_low_mid_o,
    output logic             q_high_start_o,
    output logic             q_sample_o,
    output logic             busy_o,
    output logic             hs_active_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div_m1;
        tcfg_t            cfg;
    } hold_t;

    hold_t      hold_d, hold_q;
    tcfg_t      dec_cfg;
    logic       tick;
    logic       busy;
    logic [3:0] qtr;

    scl_tg_decode #(.REG_W(REG_W)) u_decode (
        .tim_cfg_i (tim_cfg_i),
        .hs_cfg_i  (hs_cfg_i),
        .cfg_o     (dec_cfg)
    );

    // configuration follows the inputs only while idle
    always_comb begin
        hold_d = hold_q;
        if (!busy) begin
            hold_d.div_m1 = div_cfg_i;
            hold_d.cfg    = dec_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    scl_tg_prediv #(.DIV_W(DIV_W)) u_prediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (busy),
        .div_m1_i (hold_q.div_m1),
        .tick_o   (tick)
    );

    scl_tg_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run_i),
        .sw_i   (phase_sw_i),
        .tick_i (tick),
        .cfg_i  (hold_q.cfg),
        .scl_o  (scl_o),
        .qtr_o  (qtr),
        .busy_o (busy),
        .hs_o   (hs_active_o)
    );

    assign busy_o         = busy;
    assign q_low_start_o  = qtr[Q_LOW_START];
    assign q_low_mid_o    = qtr[Q_LOW_MID];
    assign q_high_start_o = qtr[Q_HIGH_START];
    assign q_sample_o     = qtr[Q_HIGH_MID];

endmodule

// File: rtl/scl_tg_chk.sv
module scl_tg_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_o,
    input logic q_low_start_o,
    input logic q_low_mid_o,
    input logic q_high_start_o,
    input logic q_sample_o,
    input logic busy_o,
    input logic hs_active_o
);

    // R6
    half_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_low_start_o || q_low_mid_o) |-> !(q_high_start_o || q_sample_o));

    // R6
    sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_sample_o |-> scl_o);

    // R7
    idle_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> scl_o);

    // R7
    scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> q_low_start_o);

    // R8
    hs_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_active_o |-> busy_o);

    // R8
    hs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active_o) |-> (scl_o && $past(scl_o)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && ($past(busy_o) == 1'b0)) |->
        !(q_low_start_o || q_low_mid_o || q_high_start_o || q_sample_o));

endmodule

bind scl_tg_top scl_tg_chk u_chk (.*);

// File: tb/tb_scl_tg_top.sv
module tb_scl_tg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        sw = 1'b0;
    logic [7:0]  div_cfg = '0;
    logic [15:0] tim_cfg = '0;
    logic [15:0] hs_cfg = '0;
    logic scl_o, q_low_start_o, q_low_mid_o, q_high_start_o, q_sample_o;
    logic busy_o, hs_active_o;

    always #5 clk = ~clk;

    scl_tg_top dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .phase_sw_i(sw),
        .div_cfg_i(div_cfg), .tim_cfg_i(tim_cfg), .hs_cfg_i(hs_cfg),
        .scl_o(scl_o), .q_low_start_o(q_low_start_o), .q_low_mid_o(q_low_mid_o),
        .q_high_start_o(q_high_start_o), .q_sample_o(q_sample_o),
        .busy_o(busy_o), .hs_active_o(hs_active_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural reference model ----------------
    int m_c, m_D, m_nS, m_nT, m_fS, m_fT;
    bit m_busy, m_hs, m_pend, m_hsen;
    bit e_scl, e_q0, e_q1, e_q2, e_q3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_hs = 0; m_pend = 0; m_c = 0;
            e_scl = 1; e_q0 = 0; e_q1 = 0; e_q2 = 0; e_q3 = 0;
        end else begin
            e_q0 = 0; e_q1 = 0; e_q2 = 0; e_q3 = 0;
            if (!m_busy) begin
                if (run) begin
                    m_busy = 1; m_c = 0; m_hs = 0; m_pend = 0;
                    m_D  = int'(div_cfg) + 1;
                    m_nT = int'(tim_cfg & 16'h003F) + 1;
                    m_nS = int'((tim_cfg >> 8) & 16'h7) + 1;
                    m_fT = int'((hs_cfg >> 8) & 16'h7) + 1;
                    m_fS = int'((hs_cfg >> 12) & 16'h7) + 1;
                    m_hsen = ((hs_cfg & 16'h3) == 16'h3);
                end
            end else begin
                int nn, t, half, p;
                if (sw && m_hsen && !m_hs) m_pend = 1;
                nn = m_hs ? m_fS * m_fT : m_nS * m_nT;
                if ((m_c % m_D) == m_D - 1) begin
                    t = m_c / m_D;
                    half = t / nn;
                    p = t % nn;
                    e_q0 = (half == 0) && (p == 0);
                    e_q1 = (half == 0) && (p == nn / 2);
                    e_q2 = (half == 1) && (p == 0);
                    e_q3 = (half == 1) && (p == nn / 2);
                    if (e_q0) e_scl = 0;
                    if (e_q2) e_scl = 1;
                    if (t == 2 * nn - 1) begin
                        m_c = 0;
                        if (!run) begin
                            m_busy = 0; m_hs = 0; m_pend = 0;
                        end else if (m_pend) begin
                            m_hs = 1; m_pend = 0;
                        end
                    end else begin
                        m_c = m_c + 1;
                    end
                end else begin
                    m_c = m_c + 1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison and event log ----------------
    int m_err = 0, m_chk = 0;
    int q0_cyc[$];
    int q2_cyc[$];
    int q3_cyc[$];

    task automatic mcheck(input bit ok, input string tag, input int act, input int exp);
        m_chk++;
        if (!ok) begin
            m_err++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            mcheck(scl_o === e_scl, "R7 scl", int'(scl_o), int'(e_scl));
            mcheck(q_low_start_o === e_q0, "R6 low start", int'(q_low_start_o), int'(e_q0));
            mcheck(q_low_mid_o === e_q1, "R6 low mid", int'(q_low_mid_o), int'(e_q1));
            mcheck(q_high_start_o === e_q2, "R6 high start", int'(q_high_start_o), int'(e_q2));
            mcheck(q_sample_o === e_q3, "R6 sample", int'(q_sample_o), int'(e_q3));
            mcheck(busy_o === m_busy, "R10 busy", int'(busy_o), int'(m_busy));
            mcheck(hs_active_o === m_hs, "R8 hs_active", int'(hs_active_o), int'(m_hs));
            if (q_low_start_o) q0_cyc.push_back(cyc);
            if (q_high_start_o) q2_cyc.push_back(cyc);
            if (q_sample_o) q3_cyc.push_back(cyc);
        end
    end

    // ---------------- directed checks ----------------
    int d_err = 0, d_chk = 0;
    bit done = 0;

    task automatic dcheck(input bit ok, input string tag, input int act, input int exp);
        d_chk++;
        if (!ok) begin
            d_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        run = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_sw();
        sw = 1'b1;
        @(negedge clk);
        sw = 1'b0;
    endtask

    initial begin
        int idx, c0, n2;
        repeat (3) @(negedge clk);
        // R11 reset state
        dcheck(scl_o === 1'b1, "R11 scl in reset", int'(scl_o), 1);
        dcheck({q_low_start_o, q_low_mid_o, q_high_start_o, q_sample_o} === 4'b0,
               "R11 strobes in reset",
               int'({q_low_start_o, q_low_mid_o, q_high_start_o, q_sample_o}), 0);
        dcheck(busy_o === 1'b0 && hs_active_o === 1'b0, "R11 busy/hs in reset",
               int'({busy_o, hs_active_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // divider 1, one sample, one step: coincident strobes, two-cycle period
        div_cfg = 8'd0; tim_cfg = 16'h0000; hs_cfg = 16'h0000;
        idx = q0_cyc.size(); c0 = cyc; run = 1'b1;
        repeat (12) @(negedge clk);
        dcheck(q0_cyc[idx] - c0 - 1 == 1, "R5 start delay D=1", q0_cyc[idx] - c0 - 1, 1);
        dcheck(q0_cyc[idx + 2] - q0_cyc[idx + 1] == 2, "R1 period 1x1x1",
               q0_cyc[idx + 2] - q0_cyc[idx + 1], 2);
        go_idle();

        // divider 4, S=3, T=5 with junk in unused bits; config changed while busy
        div_cfg = 8'd3; tim_cfg = 16'hFAC4;
        idx = q0_cyc.size(); c0 = cyc; run = 1'b1;
        repeat (130) @(negedge clk);
        div_cfg = 8'd0; tim_cfg = 16'h0000;
        repeat (270) @(negedge clk);
        dcheck(q0_cyc[idx] - c0 - 1 == 4, "R2 R5 start delay D=4", q0_cyc[idx] - c0 - 1, 4);
        dcheck(q0_cyc[idx + 1] - q0_cyc[idx] == 120, "R1 R3 period 4x3x5",
               q0_cyc[idx + 1] - q0_cyc[idx], 120);
        dcheck(q0_cyc[idx + 3] - q0_cyc[idx + 2] == 120, "R9 period after busy write",
               q0_cyc[idx + 3] - q0_cyc[idx + 2], 120);
        go_idle();

        // largest counter product: S=8, T=64
        div_cfg = 8'd0; tim_cfg = 16'h073F;
        idx = q0_cyc.size(); n2 = q2_cyc.size(); run = 1'b1;
        repeat (2100) @(negedge clk);
        dcheck(q0_cyc[idx + 1] - q0_cyc[idx] == 1024, "R1 period 1x8x64",
               q0_cyc[idx + 1] - q0_cyc[idx], 1024);
        dcheck(q3_cyc[n2] - q2_cyc[n2] == 256, "R6 sample midpoint 8x64",
               q3_cyc[n2] - q2_cyc[n2], 256);
        go_idle();

        // high speed enabled: idle pulse ignored, busy pulse switches at boundary
        div_cfg = 8'd1; tim_cfg = 16'h0102; hs_cfg = 16'h1303;
        pulse_sw();
        @(negedge clk);
        idx = q0_cyc.size(); run = 1'b1;
        repeat (60) @(negedge clk);
        dcheck(hs_active_o === 1'b0, "R8 idle switch ignored", int'(hs_active_o), 0);
        dcheck(q0_cyc[idx + 1] - q0_cyc[idx] == 24, "R8 master-code period",
               q0_cyc[idx + 1] - q0_cyc[idx], 24);
        pulse_sw();
        repeat (120) @(negedge clk);
        dcheck(hs_active_o === 1'b1, "R8 hs set active", int'(hs_active_o), 1);
        dcheck(q0_cyc[$] - q0_cyc[$ - 1] == 32, "R4 R8 high-speed period",
               q0_cyc[$] - q0_cyc[$ - 1], 32);
        go_idle();
        dcheck(hs_active_o === 1'b0, "R10 hs cleared at idle", int'(hs_active_o), 0);

        // wrong enable code: switch pulse has no effect
        hs_cfg = 16'h1302;
        run = 1'b1;
        repeat (10) @(negedge clk);
        pulse_sw();
        repeat (150) @(negedge clk);
        dcheck(hs_active_o === 1'b0, "R4 disabled hs ignored", int'(hs_active_o), 0);
        dcheck(q0_cyc[$] - q0_cyc[$ - 1] == 24, "R4 period stays normal",
               q0_cyc[$] - q0_cyc[$ - 1], 24);
        go_idle();

        // early drop of run: current period completes
        div_cfg = 8'd0; tim_cfg = 16'h0101; hs_cfg = 16'h0000;
        n2 = q2_cyc.size(); run = 1'b1;
        repeat (3) @(negedge clk);
        run = 1'b0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
        dcheck(q2_cyc.size() - n2 == 1, "R10 final period completed", q2_cyc.size() - n2, 1);
        dcheck(scl_o === 1'b1, "R10 R7 scl high after stop", int'(scl_o), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", m_err + d_err, m_chk + d_chk);
        $finish;
    end

    // watchdog
    always @(negedge clk) begin
        if (!done && cyc > 100000) begin
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", m_err + d_err + 1, m_chk + d_chk + 1);
            $finish;
        end
    end

endmodule